// File: doc/BRIEF.md
# Wrapped Burst Read Address Sequencer

This block supplies the byte address for each step of a quad I/O fast read inside a serial flash model. A configuration byte, delivered by the set-burst-with-wrap command, chooses whether the read stays inside an aligned window and how wide that window is. A start strobe loads the 24-bit address that the read command carries. After that, one advance strobe per delivered byte moves the address to the next byte.

When wrapping is on, the address runs around inside an aligned window of 8, 16, 32 or 64 bytes that contains the start address. When wrapping is off, the read is linear across the whole 24-bit space and rolls from the top address back to zero. The enable bit in the configuration byte is active low. After reset, wrapping is off and the 64-byte length is selected, so plain sequential reads work until a configuration byte turns wrapping on.

Top module: `qwrap_addr_gen`

## Requirements
- R1: After reset, `cur_addr` is 0, `wrap_on` is 0 and `wrap_len_sel` is 2'b11.
- R2: A `cfg_load` pulse captures bit 4 of `cfg_byte` as an active-low wrap enable. From the next cycle, `wrap_on` equals the inverse of that bit.
- R3: A `cfg_load` pulse captures bits 6:5 of `cfg_byte` as the length select (00 = 8, 01 = 16, 10 = 32, 11 = 64 bytes). From the next cycle this select appears on `wrap_len_sel`. Bits 7 and 3:0 of `cfg_byte` have no effect on any output.
- R4: A `rd_start` pulse loads `start_addr` into `cur_addr` in the next cycle.
- R5: With wrapping off, a `byte_adv` pulse moves `cur_addr` to `cur_addr + 1`, taken modulo 2^24. The address FFFFFFh is followed by 000000h.
- R6: With wrapping on, a `byte_adv` pulse has three effects. The low log2(length) bits of `cur_addr` step by one, taken modulo the selected length. The remaining upper bits keep their value. The length is the one that `wrap_len_sel` shows.
- R7: When `rd_start` and `byte_adv` arrive in the same cycle, `rd_start` wins and the advance has no effect.
- R8: With neither `rd_start` nor `byte_adv` asserted, `cur_addr` holds its value.
- R9: When `cfg_load` and `byte_adv` arrive in the same cycle, the advance uses the configuration that was in effect before the load.
- R10: Without `cfg_load`, the configuration does not change, whatever `rd_start` and `byte_adv` do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_load | input | 1 | Load strobe for the wrap configuration byte |
| cfg_byte | input | 8 | Configuration byte: bit 4 = wrap disable, bits 6:5 = length select |
| rd_start | input | 1 | Start strobe for a read |
| start_addr | input | 24 | Start byte address of the read |
| byte_adv | input | 1 | Advance strobe, one pulse per delivered byte |
| cur_addr | output | 24 | Current byte address |
| wrap_on | output | 1 | Wrapping is active |
| wrap_len_sel | output | 2 | Selected wrap length code |

## Verification
Two pairs of strobes can land in the same clock edge. A start can meet an advance, in which case the start address must win. A configuration load can meet an advance, in which case the step must still follow the old wrap setting, and the new one applies only from the next byte. Directed cases place each pair at a window edge, where the old and new behaviour would give different addresses. The random phase also lets all three strobes collide freely. Every collision is judged against a bench model that applies the configuration one cycle late.

// File: rtl/qwrap_pkg.sv
package qwrap_pkg;
    localparam int SEL_W    = 2;
    localparam int CFG_W    = 8;

    typedef struct packed {
        logic             wrap_dis;
        logic [SEL_W-1:0] len_sel;
    } wrap_cfg_t;

    localparam wrap_cfg_t CFG_RESET = '{wrap_dis: 1'b1, len_sel: '1};
endpackage

// File: rtl/qwrap_cfg_reg.sv
module qwrap_cfg_reg
    import qwrap_pkg::*;
#(
    parameter int EN_BIT  = 4,
    parameter int SEL_LSB = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CFG_W-1:0] cfg_byte,
    output wrap_cfg_t        cfg
);
    wrap_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (load) begin
            cfg_d.wrap_dis = cfg_byte[EN_BIT];
            cfg_d.len_sel  = cfg_byte[SEL_LSB +: SEL_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_RESET;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

    // R2: active-low enable captured on load
    assert_cfg_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cfg.wrap_dis == $past(cfg_byte[EN_BIT]));
    // R3: length select captured on load
    assert_cfg_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cfg.len_sel == $past(cfg_byte[SEL_LSB +: SEL_W]));
    // R10: configuration is held without a load
    assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(cfg));
endmodule

// File: rtl/qwrap_step.sv
module qwrap_step
    import qwrap_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int MIN_LOG2 = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wrap_on,
    input  logic [SEL_W-1:0]  len_sel,
    output logic [ADDR_W-1:0] nxt
);
    localparam int NSEL = 1 << SEL_W;

    logic [ADDR_W-1:0] masks [NSEL];
    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] inc;

    for (genvar i = 0; i < NSEL; i++) begin : g_mask
        assign masks[i] = ADDR_W'((64'd1 << (MIN_LOG2 + i)) - 64'd1);
    end

    always_comb begin
        mask = masks[len_sel];
        inc  = addr + ADDR_W'(1);
        if (wrap_on) nxt = (addr & ~mask) | (inc & mask);
        else         nxt = inc;
    end
endmodule

// File: rtl/qwrap_addr_gen.sv
module qwrap_addr_gen
    import qwrap_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int MIN_LOG2 = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic [7:0]        cfg_byte,
    input  logic              rd_start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              byte_adv,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              wrap_on,
    output logic [1:0]        wrap_len_sel
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
    } seq_state_t;

    wrap_cfg_t         cfg;
    logic [ADDR_W-1:0] step_addr;
    seq_state_t        st_d, st_q;

    qwrap_cfg_reg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cfg_load),
        .cfg_byte (cfg_byte),
        .cfg      (cfg)
    );

    qwrap_step #(.ADDR_W(ADDR_W), .MIN_LOG2(MIN_LOG2)) u_step (
        .addr    (st_q.addr),
        .wrap_on (!cfg.wrap_dis),
        .len_sel (cfg.len_sel),
        .nxt     (step_addr)
    );

    always_comb begin
        st_d = st_q;
        if (rd_start)      st_d.addr = start_addr;
        else if (byte_adv) st_d.addr = step_addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur_addr     = st_q.addr;
    assign wrap_on      = !cfg.wrap_dis;
    assign wrap_len_sel = cfg.len_sel;

    // R4 and R7: start loads the address and overrides an advance
    assert_start_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |=> cur_addr == $past(start_addr));
    // R8: idle cycle keeps the address
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_start && !byte_adv |=> $stable(cur_addr));
    // R5: linear step
    assert_linear_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        byte_adv && !rd_start && !wrap_on |=> cur_addr == $past(cur_addr) + ADDR_W'(1));
    // R6: upper bits stay inside the window
    assert_window_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        byte_adv && !rd_start && wrap_on |=>
        (cur_addr >> (MIN_LOG2 + int'($past(wrap_len_sel)))) ==
        ($past(cur_addr) >> (MIN_LOG2 + int'($past(wrap_len_sel)))));
endmodule

// File: tb/sim_qwrap_addr_gen.sv
module sim_qwrap_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 1'b0;
    logic [7:0]  cfg_byte = '0;
    logic        rd_start = 1'b0;
    logic [23:0] start_addr = '0;
    logic        byte_adv = 1'b0;
    logic [23:0] cur_addr;
    logic        wrap_on;
    logic [1:0]  wrap_len_sel;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [23:0] e_addr = '0;
    logic        e_on = 1'b0;
    logic [1:0]  e_sel = 2'b11;

    always #10 clk = ~clk;

    qwrap_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_byte(cfg_byte),
        .rd_start(rd_start), .start_addr(start_addr), .byte_adv(byte_adv),
        .cur_addr(cur_addr), .wrap_on(wrap_on), .wrap_len_sel(wrap_len_sel)
    );

    function automatic logic [23:0] model_next(logic [23:0] a, logic on, logic [1:0] sel);
        logic [23:0] m;
        m = (24'd8 << sel) - 24'd1;
        if (!on) return a + 24'd1;
        return (a & ~m) | ((a + 24'd1) & m);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(logic ld, logic [7:0] cb, logic st, logic [23:0] sa, logic adv, string req);
        @(negedge clk);
        cfg_load = ld; cfg_byte = cb; rd_start = st; start_addr = sa; byte_adv = adv;
        @(posedge clk);
        if (st)       e_addr = sa;
        else if (adv) e_addr = model_next(e_addr, e_on, e_sel);
        if (ld) begin e_on = !cb[4]; e_sel = cb[6:5]; end
        #2;
        check(req, {8'h0, cur_addr}, {8'h0, e_addr});
        check(req, {30'h0, wrap_len_sel}, {30'h0, e_sel});
        check(req, {31'h0, wrap_on}, {31'h0, e_on});
        cfg_load = 1'b0; rd_start = 1'b0; byte_adv = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1", {8'h0, cur_addr}, 32'h0);
        check("R1", {31'h0, wrap_on}, 32'h0);
        check("R1", {30'h0, wrap_len_sel}, 32'h3);
        // R5 linear after reset, rollover
        step(0, 0, 1, 24'hFFFFFE, 0, "R4");
        step(0, 0, 0, 0, 1, "R5");
        step(0, 0, 0, 0, 1, "R5");
        step(0, 0, 0, 0, 0, "R8");
        // R2/R3 enable 8-byte wrap
        step(1, 8'h00, 0, 0, 0, "R2");
        step(0, 0, 1, 24'h000006, 0, "R4");
        repeat (3) step(0, 0, 0, 0, 1, "R6");
        // R3 other bits ignored: 0xAF -> on, 16 bytes
        step(1, 8'hAF, 1, 24'hABCD1E, 0, "R3");
        repeat (3) step(0, 0, 0, 0, 1, "R6");
        // 64-byte wrap
        step(1, 8'h60, 1, 24'h12347E, 0, "R3");
        repeat (2) step(0, 0, 0, 0, 1, "R6");
        // R7 start with advance
        step(0, 0, 1, 24'h00003F, 1, "R7");
        // R9 load (disable) with advance at window edge: old wrap applies
        step(1, 8'h10, 0, 0, 1, "R9");
        step(0, 0, 1, 24'h00003F, 0, "R4");
        step(0, 0, 0, 0, 1, "R5");
        // R10 config held over strobes
        step(0, 8'hFF, 1, 24'h000010, 1, "R10");
        // random phase
        for (int i = 0; i < 3000; i++) begin
            logic ld, st, adv;
            logic [7:0] cb;
            logic [23:0] sa;
            string tag;
            ld = ($urandom % 10) == 0;
            st = ($urandom % 12) == 0;
            adv = ($urandom % 4) != 0;
            cb = 8'($urandom);
            sa = (($urandom % 4) == 0) ? 24'hFFFFF8 | 24'($urandom % 8) : 24'($urandom);
            if (st && adv)      tag = "R7";
            else if (st)        tag = "R4";
            else if (ld && adv) tag = "R9";
            else if (adv)       tag = e_on ? "R6" : "R5";
            else if (ld)        tag = "R2";
            else                tag = "R8";
            step(ld, cb, st, sa, adv, tag);
        end
        done = 1'b1;
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule